// File: doc/BRIEF.md
# Codec Sample-Rate Strobe Generator

This block derives the converter sample strobe from an internal audio master clock that runs at 256 times a reference sample rate. One configuration byte carries two 4-bit ratio codes, one for the playback converter and one for the record converter. Because both converters share a single sample rate, the two codes must agree. A separate mode input halves the strobe period, which doubles the sample rate.

Code k selects a divide ratio of 1 + k/2, so the ratio moves in half steps from 1 to 6. With that ratio the strobe period is always a whole number of master-clock cycles: 128 × (k + 2) at the normal rate and 64 × (k + 2) at the double rate. A single down-counter, sequenced by a small state machine, produces a one-cycle `sample_en` pulse once per period. A bad configuration raises `cfg_err`. While it is bad, the block keeps its last accepted setting. A new setting is taken only at a strobe boundary.

The sequencer has three states:
- `ST_LOAD` is entered from reset. It always moves to `ST_RUN` and loads the first period.
- `ST_RUN` counts down. It stays in `ST_RUN` while the counter is nonzero and moves to `ST_FIRE` when the counter reaches zero.
- `ST_FIRE` drives the pulse. It always returns to `ST_RUN`, latches the selected setting and reloads the counter.

Top module: `srate_strobe_gen`

## Requirements
- R1: While `rst_n` is low, `sample_en` and `cfg_err` are both 0.
- R2: The first `sample_en` pulse is high exactly P cycles after reset is released, counted in rising edges. P is the period of the configuration present at the first edge after release. If that configuration is invalid, P is 256.
- R3: `sample_en` is never high for two consecutive cycles.
- R4: With `dbl_rate` = 0, valid code k (0..10) gives a strobe period of 128 × (k + 2) cycles. k = 10 gives the longest period, 1536.
- R5: With `dbl_rate` = 1, valid code k gives a strobe period of 64 × (k + 2) cycles. k = 0 gives the shortest period, 128.
- R6: If `cfg_byte[7:4]` differs from `cfg_byte[3:0]`, `cfg_err` is 1 on the cycle after that value is sampled. At a boundary the active code and rate mode are kept unchanged.
- R7: If both nibbles are equal but hold a code from 11 to 15, `cfg_err` is 1 on the cycle after sampling. The active setting is kept unchanged.
- R8: The configuration (code and `dbl_rate`) is sampled only on the edge that ends a `sample_en` cycle. A change during a period leaves that period's length unchanged and applies to the following period.
- R9: A valid configuration (equal nibbles, code 0..10) gives `cfg_err` = 0 on the cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock at 256 × reference sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte | input | 8 | Ratio codes: bits 7:4 playback, bits 3:0 record |
| dbl_rate | input | 1 | 1 selects double sample rate (half period) |
| sample_en | output | 1 | One-cycle sample strobe shared by both converters |
| cfg_err | output | 1 | Registered flag: last sampled configuration is invalid |

## Verification
The assertions check four things on every cycle:
- the pulse is a single cycle;
- `cfg_err` follows the validity of the sampled byte one cycle later, both for nibble mismatches and for out-of-range codes;
- the spacing between strobes never falls below the shortest legal period;
- the spacing never exceeds the longest legal period.

Only the bench scenarios can show the exact period for each code and mode, the exact cycle of the first strobe after reset, and the retention of the last valid setting across invalid bytes. The same applies to changes made in the middle of a period: they must not alter that period's length and must take effect at the next boundary.

// File: rtl/srate_pkg.sv
package srate_pkg;

    // Sequencer states of the strobe generator
    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,   // first cycle after reset: pick the initial setting
        ST_RUN  = 2'd1,   // counting down the current period
        ST_FIRE = 2'd2    // strobe cycle, boundary for a new setting
    } seq_state_t;

    // Packed description of an active rate setting
    typedef struct packed {
        logic [3:0] code;
        logic       dbl;
    } rate_set_t;

endpackage

// File: rtl/srate_cfg_check.sv
module srate_cfg_check #(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 10,
    localparam int CFG_W   = 2 * CODE_W
) (
    input  logic [CFG_W-1:0]  cfg,
    output logic [CODE_W-1:0] code,
    output logic              mismatch,
    output logic              out_of_range,
    output logic              cfg_ok
);

    logic [CODE_W-1:0] hi_code;
    logic [CODE_W-1:0] lo_code;

    always_comb begin
        hi_code      = cfg[CFG_W-1:CODE_W];
        lo_code      = cfg[CODE_W-1:0];
        mismatch     = (hi_code != lo_code);
        out_of_range = (lo_code > CODE_W'(MAX_CODE));
        cfg_ok       = !mismatch && !out_of_range;
        code         = lo_code;
    end

endmodule

// File: rtl/srate_period_calc.sv
module srate_period_calc #(
    parameter int CODE_W   = 4,
    parameter int BASE_CYC = 64,
    parameter int PW       = 11
) (
    input  logic [CODE_W-1:0] code,
    input  logic              dbl,
    output logic [PW-1:0]     period
);

    // Ratio 1 + k/2 scaled by two gives (k + 2) half-steps
    logic [PW-1:0] half_steps;
    logic [PW-1:0] unit_cyc;

    always_comb begin
        half_steps = PW'(code) + PW'(2);
        unit_cyc   = dbl ? PW'(BASE_CYC) : PW'(2 * BASE_CYC);
        period     = half_steps * unit_cyc;
    end

endmodule

// File: rtl/srate_seq.sv
module srate_seq
    import srate_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int PW       = 11,
    parameter int DEF_CODE = 0,
    parameter bit DEF_DBL  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ok,
    input  logic [CODE_W-1:0] code_in,
    input  logic              dbl_in,
    input  logic [PW-1:0]     period,
    output logic [CODE_W-1:0] sel_code,
    output logic              sel_dbl,
    output logic              strobe,
    output logic              err_flag
);

    seq_state_t        state_q;
    seq_state_t        state_d;
    logic [PW-1:0]     cnt_q;
    logic [CODE_W-1:0] act_code_q;
    logic              act_dbl_q;
    logic              load;

    // Setting that would be latched at a boundary in this cycle
    always_comb begin
        sel_code = cfg_ok ? code_in : act_code_q;
        sel_dbl  = cfg_ok ? dbl_in  : act_dbl_q;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                state_d = ST_RUN;
                load    = 1'b1;
            end
            ST_RUN: begin
                if (cnt_q == '0) begin
                    state_d = ST_FIRE;
                end
            end
            ST_FIRE: begin
                state_d = ST_RUN;
                load    = 1'b1;
            end
            default: begin
                state_d = ST_LOAD;
            end
        endcase
    end

    // State register, counter and active setting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_LOAD;
            cnt_q      <= '0;
            act_code_q <= CODE_W'(DEF_CODE);
            act_dbl_q  <= DEF_DBL;
        end else begin
            state_q <= state_d;
            if (load) begin
                // FIRE is entered P-1 edges after the load edge
                cnt_q      <= period - PW'(2);
                act_code_q <= sel_code;
                act_dbl_q  <= sel_dbl;
            end else if (state_q == ST_RUN && cnt_q != '0) begin
                cnt_q <= cnt_q - PW'(1);
            end
        end
    end

    // Registered configuration error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else begin
            err_flag <= !cfg_ok;
        end
    end

    // Output decode
    always_comb begin
        strobe = (state_q == ST_FIRE);
    end

endmodule

// File: rtl/srate_strobe_gen.sv
module srate_strobe_gen #(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 10,
    parameter int BASE_CYC = 64,
    parameter int DEF_CODE = 0,
    localparam int CFG_W   = 2 * CODE_W,
    localparam int PER_MAX = BASE_CYC * 2 * (MAX_CODE + 2),
    localparam int PW      = $clog2(PER_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_byte,
    input  logic             dbl_rate,
    output logic             sample_en,
    output logic             cfg_err
);

    logic [CODE_W-1:0] dec_code;
    logic              dec_mismatch;
    logic              dec_range;
    logic              dec_ok;
    logic [CODE_W-1:0] sel_code;
    logic              sel_dbl;
    logic [PW-1:0]     sel_period;

    srate_cfg_check #(
        .CODE_W   (CODE_W),
        .MAX_CODE (MAX_CODE)
    ) u_check (
        .cfg          (cfg_byte),
        .code         (dec_code),
        .mismatch     (dec_mismatch),
        .out_of_range (dec_range),
        .cfg_ok       (dec_ok)
    );

    srate_period_calc #(
        .CODE_W   (CODE_W),
        .BASE_CYC (BASE_CYC),
        .PW       (PW)
    ) u_calc (
        .code   (sel_code),
        .dbl    (sel_dbl),
        .period (sel_period)
    );

    srate_seq #(
        .CODE_W   (CODE_W),
        .PW       (PW),
        .DEF_CODE (DEF_CODE),
        .DEF_DBL  (1'b0)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_ok   (dec_ok),
        .code_in  (dec_code),
        .dbl_in   (dbl_rate),
        .period   (sel_period),
        .sel_code (sel_code),
        .sel_dbl  (sel_dbl),
        .strobe   (sample_en),
        .err_flag (cfg_err)
    );

endmodule

// File: rtl/srate_strobe_chk.sv
module srate_strobe_chk #(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 10,
    parameter int BASE_CYC = 64,
    localparam int CFG_W   = 2 * CODE_W,
    localparam int PER_MIN = BASE_CYC * 2,
    localparam int PER_MAX = BASE_CYC * 2 * (MAX_CODE + 2),
    localparam int GW      = $clog2(PER_MAX + 2) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg_byte,
    input logic             dbl_rate,
    input logic             sample_en,
    input logic             cfg_err
);

    logic [CODE_W-1:0] hi_n;
    logic [CODE_W-1:0] lo_n;
    logic [GW-1:0]     gap;

    assign hi_n = cfg_byte[CFG_W-1:CODE_W];
    assign lo_n = cfg_byte[CODE_W-1:0];

    // Cycles since reset or since the last strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (sample_en) begin
            gap <= GW'(1);
        end else if (gap != {GW{1'b1}}) begin
            gap <= gap + GW'(1);
        end
    end

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> !sample_en);

    // R6
    mismatch_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_n != lo_n) |=> cfg_err);

    // R7
    range_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_n == lo_n) && (lo_n > CODE_W'(MAX_CODE))) |=> cfg_err);

    // R9
    valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_n == lo_n) && (lo_n <= CODE_W'(MAX_CODE))) |=> !cfg_err);

    // R5
    min_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> (gap >= GW'(PER_MIN)));

    // R4
    max_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap <= GW'(PER_MAX));

    // dbl_rate is observed only through the strobe spacing
    logic unused_dbl;
    assign unused_dbl = dbl_rate;

endmodule

bind srate_strobe_gen srate_strobe_chk #(
    .CODE_W   (CODE_W),
    .MAX_CODE (MAX_CODE),
    .BASE_CYC (BASE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_byte  (cfg_byte),
    .dbl_rate  (dbl_rate),
    .sample_en (sample_en),
    .cfg_err   (cfg_err)
);

// File: tb/tb_srate_strobe_gen.sv
module tb_srate_strobe_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_byte = 8'h00;
    logic       dbl_rate = 1'b0;
    logic       sample_en;
    logic       cfg_err;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    int    exp_q[$];
    string req_q[$];
    int    act_k = 0;
    bit    act_d = 1'b0;

    srate_strobe_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_byte  (cfg_byte),
        .dbl_rate  (dbl_rate),
        .sample_en (sample_en),
        .cfg_err   (cfg_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    function automatic int per_of(int k, bit d);
        return (k + 2) * (d ? 64 : 128);
    endfunction

    function automatic bit is_valid(logic [7:0] c);
        return (c[7:4] == c[3:0]) && (c[3:0] <= 4'd10);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected strobe cycles and compares
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (exp_q.size() > 0 && cyc == exp_q[0]) begin
                check(req_q[0], sample_en, 1);
                void'(exp_q.pop_front());
                void'(req_q.pop_front());
            end else if (sample_en) begin
                // R3 also caught here: no strobe outside expected cycles
                check("R3 unexpected strobe", cyc, (exp_q.size() > 0) ? exp_q[0] : -1);
            end
        end
    end

    task automatic wait_strobe();
        do @(negedge clk); while (!sample_en);
    endtask

    // Driver: applies a setting at a boundary and queues the next strobe
    task automatic at_boundary(logic [7:0] c, bit d, string req);
        bit ok;
        cfg_byte = c;
        dbl_rate = d;
        ok = is_valid(c);
        if (ok) begin
            act_k = int'(c[3:0]);
            act_d = d;
        end
        exp_q.push_back(cyc + per_of(act_k, act_d));
        req_q.push_back(req);
        @(negedge clk);
        check({req, " cfg_err"}, cfg_err, ok ? 0 : 1);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 sample_en", sample_en, 0);
        check("R1 cfg_err", cfg_err, 0);
        // R2 first strobe one full period after release
        exp_q.push_back(per_of(0, 1'b0));
        req_q.push_back("R2 first strobe");
        rst_n = 1'b1;

        wait_strobe();
        at_boundary(8'hAA, 1'b0, "R4 longest period k=10");
        wait_strobe();
        at_boundary(8'h33, 1'b1, "R5 double rate k=3");
        wait_strobe();
        at_boundary(8'h35, 1'b0, "R6 mismatch keeps setting");
        wait_strobe();
        at_boundary(8'hBB, 1'b0, "R7 code 11 keeps setting");
        wait_strobe();
        at_boundary(8'h00, 1'b1, "R5 shortest period, R9 clear");
        wait_strobe();
        at_boundary(8'h55, 1'b0, "R4 k=5");
        // R8 mid-period change must not alter the running period
        repeat (40) @(negedge clk);
        cfg_byte = 8'h11;
        dbl_rate = 1'b1;
        @(negedge clk);
        check("R9 mid-period valid", cfg_err, 0);
        wait_strobe();
        at_boundary(8'h11, 1'b1, "R8 new setting at boundary");
        wait_strobe();
        at_boundary(8'h22, 1'b0, "R4 k=2");
        wait_strobe();
        at_boundary(8'hFF, 1'b1, "R7 code 15 keeps setting");
        wait_strobe();
        at_boundary(8'hA0, 1'b1, "R6 mismatch again");
        wait_strobe();
        @(negedge clk);
        check("R8 queue drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule